// File: doc/BRIEF.md
# Hierarchical Performance Counter Controller

This block is a small performance-monitoring unit. It holds a bank of wide event counters. Each counter picks one of several event strobe lines through its own configuration register. A counter advances only while its own enable bit and a shared master enable bit are both set, so software can arm the counters one by one and then start or stop them all with a single write. A simple register port writes and reads the master control word, the per-counter configuration, the counter values and a sticky overflow summary.

When a counter wraps from all ones to zero, two separate things can follow. If that counter's interrupt enable is set, its summary bit is set and a single-cycle interrupt pulse goes to the core chosen by a select field in the master control word. If the freeze bit in the master control word is also set, the hardware clears the master enable, and every counter stops. The interrupt and the freeze are governed by separate bits, so either can be used without the other.

Top module: `pmu_ctr_top`

## Requirements
- R1: After reset all counter values, the summary register, the interrupt vector and every control bit are zero, so nothing counts.
- R2: A counter adds one on each clock edge at which its selected event line is high, its local enable (configuration bit 0) is set and the master enable (control bit 0) is set. If either enable is clear, the value does not change.
- R3: The select field of a counter (configuration bits 10:8) is the index of the event line that it counts. Code 3, for example, counts line 3 only.
- R4: Writing a 1 to control bit 1 clears every counter value and the whole summary register at the next clock edge. The bit then reads back as 0.
- R5: A counter that counts while it holds all ones becomes zero and keeps counting upward from zero after that.
- R6: A wrap of a counter whose interrupt enable (configuration bit 1) is set sets that counter's bit in the summary register at address 0x01. The bit stays set until it is cleared. A wrap with the interrupt enable clear changes neither the summary nor the interrupt vector.
- R7: Writing the summary address clears exactly the summary bits written as 1. If a new enabled wrap occurs at the same edge, setting its bit takes priority over the clear.
- R8: When control bit 2 (freeze) is set and an enabled wrap occurs, the master enable reads back as 0 from the next cycle on, and all counters then hold their values. With freeze clear, an enabled wrap leaves the master enable set.
- R9: An enabled wrap produces a one-cycle pulse on interrupt bit N, where N is the core-select field (control bits 6:4), in the cycle after the wrap edge. This happens whatever the freeze bit is. A select value of 4 or more produces no pulse. Several counters that wrap at the same edge give one pulse.
- R10: A write to a counter value address (0x10 plus the counter index) loads that value and takes priority over a count at the same edge. Configuration addresses are 0x08 plus the counter index, and the control word is at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Event strobe lines, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| ctr_val | output | 192 | All counter values packed, counter i at bits 48*i upward |
| ovf_summary | output | 4 | Sticky overflow summary, one bit per counter |
| irq | output | 4 | One-hot interrupt pulses toward the cores |

## Verification
Two kinds of event can land on the same clock edge. The first is a software write and a hardware update of the same state: a write-1-to-clear of the summary at the edge where enabled counters wrap, or a load of a counter value at an edge where that counter would count. The bench preloads two counters with all ones and raises their event lines while it writes the summary clear in the same cycle. It then expects both summary bits set, a single interrupt pulse on the selected core and both counters at zero. In a separate case it expects the loaded value, not the incremented one, after a write made while the counter's event line is high.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int PMU_NUM_CTR  = 4;
  localparam int PMU_CTR_W    = 48;
  localparam int PMU_NUM_EVT  = 8;
  localparam int PMU_NUM_CORE = 4;
  localparam int PMU_CSEL_W   = 3;
  localparam int PMU_DATA_W   = 64;
  localparam int PMU_ADDR_W   = 6;

  // register map
  localparam int ADR_GLB      = 'h00;
  localparam int ADR_SUM      = 'h01;
  localparam int ADR_CFG_BASE = 'h08;
  localparam int ADR_VAL_BASE = 'h10;

  // master control word fields
  localparam int GLB_EN_BIT   = 0;
  localparam int GLB_RST_BIT  = 1;
  localparam int GLB_FRZ_BIT  = 2;
  localparam int GLB_CSEL_LSB = 4;

  // per-counter configuration fields
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_IRQ_BIT  = 1;
  localparam int CFG_SEL_LSB  = 8;

  // one-hot decode of a core index; out-of-range gives all zeros
  function automatic logic [15:0] pmu_sel_onehot(input logic [7:0] sel,
                                                 input int unsigned n);
    logic [15:0] r;
    r = '0;
    for (int k = 0; k < 16; k++) begin
      if ((k < int'(n)) && (int'(sel) == k)) r[k] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               glb_en,
  input  logic               clr_all,
  input  logic               cfg_wr,
  input  logic               cfg_en_d,
  input  logic               cfg_irq_d,
  input  logic [SEL_W-1:0]   cfg_sel_d,
  input  logic               val_wr,
  input  logic [CTR_W-1:0]   val_d,
  output logic [CTR_W-1:0]   cnt_q,
  output logic               en_q,
  output logic               irq_en_q,
  output logic [SEL_W-1:0]   sel_q,
  output logic               wrap,
  output logic               ovf_req
);

  // increment with carry-out; the carry marks the all-ones to zero step
  function automatic logic [CTR_W:0] inc_carry(input logic [CTR_W-1:0] v);
    return {1'b0, v} + {{CTR_W{1'b0}}, 1'b1};
  endfunction

  logic             evt_sel;
  logic             cnt_step;
  logic [CTR_W:0]   sum_c;

  always_comb begin
    evt_sel = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (int'(sel_q) == k) evt_sel = evt_in[k];
    end
  end

  assign cnt_step = en_q && glb_en && evt_sel && !clr_all && !val_wr;
  assign sum_c    = inc_carry(cnt_q);
  assign wrap     = cnt_step && sum_c[CTR_W];
  assign ovf_req  = wrap && irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_all) begin
      cnt_q <= '0;
    end else if (val_wr) begin
      cnt_q <= val_d;
    end else if (cnt_step) begin
      cnt_q <= sum_c[CTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      sel_q    <= '0;
    end else if (cfg_wr) begin
      en_q     <= cfg_en_d;
      irq_en_q <= cfg_irq_d;
      sel_q    <= cfg_sel_d;
    end
  end

endmodule

// File: rtl/pmu_glb_ctl.sv
module pmu_glb_ctl
  import pmu_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int NUM_CORE = 4,
  parameter int CSEL_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_wr,
  input  logic                en_d,
  input  logic                rst_d,
  input  logic                frz_d,
  input  logic [CSEL_W-1:0]   csel_d,
  input  logic                sum_wr,
  input  logic [NUM_CTR-1:0]  sum_clr_d,
  input  logic [NUM_CTR-1:0]  ovf_req,
  output logic                glb_en,
  output logic                rst_all_q,
  output logic                freeze_all,
  output logic [CSEL_W-1:0]   core_sel,
  output logic [NUM_CTR-1:0]  summary,
  output logic [NUM_CORE-1:0] irq,
  output logic                ovf_hit
);

  logic [NUM_CTR-1:0]  sum_nxt;
  logic [15:0]         core_oh;

  assign ovf_hit = |ovf_req;
  assign core_oh = pmu_sel_onehot(8'(core_sel), NUM_CORE);

  always_comb begin
    sum_nxt = summary;
    if (sum_wr)    sum_nxt = sum_nxt & ~sum_clr_d;
    if (rst_all_q) sum_nxt = '0;
    sum_nxt = sum_nxt | ovf_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en     <= 1'b0;
      rst_all_q  <= 1'b0;
      freeze_all <= 1'b0;
      core_sel   <= '0;
    end else begin
      rst_all_q <= glb_wr && rst_d;
      if (glb_wr) begin
        glb_en     <= en_d;
        freeze_all <= frz_d;
        core_sel   <= csel_d;
      end
      if (ovf_hit && freeze_all) glb_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summary <= '0;
      irq     <= '0;
    end else begin
      summary <= sum_nxt;
      irq     <= ovf_hit ? core_oh[NUM_CORE-1:0] : '0;
    end
  end

endmodule

// File: rtl/pmu_ctr_top.sv
module pmu_ctr_top
  import pmu_pkg::*;
#(
  parameter int NUM_CTR  = PMU_NUM_CTR,
  parameter int CTR_W    = PMU_CTR_W,
  parameter int NUM_EVT  = PMU_NUM_EVT,
  parameter int NUM_CORE = PMU_NUM_CORE,
  parameter int CSEL_W   = PMU_CSEL_W,
  parameter int DATA_W   = PMU_DATA_W,
  parameter int ADDR_W   = PMU_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT-1:0]       evt_in,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [NUM_CTR*CTR_W-1:0] ctr_val,
  output logic [NUM_CTR-1:0]       ovf_summary,
  output logic [NUM_CORE-1:0]      irq
);

  localparam int SEL_W = $clog2(NUM_EVT);

  // named internal events, used by the checker
  logic                glb_wr;
  logic                sum_wr;
  logic [NUM_CTR-1:0]  cfg_wr;
  logic [NUM_CTR-1:0]  val_wr;
  logic [NUM_CTR-1:0]  ctr_wrap;
  logic [NUM_CTR-1:0]  ovf_req;
  logic                ovf_hit;
  logic                glb_en;
  logic                rst_all_q;
  logic                freeze_all;
  logic [CSEL_W-1:0]   core_sel;

  logic [CTR_W-1:0]    cnt_q   [NUM_CTR];
  logic                en_q    [NUM_CTR];
  logic                irqen_q [NUM_CTR];
  logic [SEL_W-1:0]    sel_q   [NUM_CTR];

  assign glb_wr = reg_wr && (int'(reg_addr) == ADR_GLB);
  assign sum_wr = reg_wr && (int'(reg_addr) == ADR_SUM);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cfg_wr[i] = reg_wr && (int'(reg_addr) == ADR_CFG_BASE + i);
    assign val_wr[i] = reg_wr && (int'(reg_addr) == ADR_VAL_BASE + i);

    pmu_evt_ctr #(
      .CTR_W   (CTR_W),
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_in    (evt_in),
      .glb_en    (glb_en),
      .clr_all   (rst_all_q),
      .cfg_wr    (cfg_wr[i]),
      .cfg_en_d  (reg_wdata[CFG_EN_BIT]),
      .cfg_irq_d (reg_wdata[CFG_IRQ_BIT]),
      .cfg_sel_d (reg_wdata[CFG_SEL_LSB +: SEL_W]),
      .val_wr    (val_wr[i]),
      .val_d     (reg_wdata[CTR_W-1:0]),
      .cnt_q     (cnt_q[i]),
      .en_q      (en_q[i]),
      .irq_en_q  (irqen_q[i]),
      .sel_q     (sel_q[i]),
      .wrap      (ctr_wrap[i]),
      .ovf_req   (ovf_req[i])
    );

    assign ctr_val[i*CTR_W +: CTR_W] = cnt_q[i];
  end

  pmu_glb_ctl #(
    .NUM_CTR  (NUM_CTR),
    .NUM_CORE (NUM_CORE),
    .CSEL_W   (CSEL_W)
  ) u_glb (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_wr     (glb_wr),
    .en_d       (reg_wdata[GLB_EN_BIT]),
    .rst_d      (reg_wdata[GLB_RST_BIT]),
    .frz_d      (reg_wdata[GLB_FRZ_BIT]),
    .csel_d     (reg_wdata[GLB_CSEL_LSB +: CSEL_W]),
    .sum_wr     (sum_wr),
    .sum_clr_d  (reg_wdata[NUM_CTR-1:0]),
    .ovf_req    (ovf_req),
    .glb_en     (glb_en),
    .rst_all_q  (rst_all_q),
    .freeze_all (freeze_all),
    .core_sel   (core_sel),
    .summary    (ovf_summary),
    .irq        (irq),
    .ovf_hit    (ovf_hit)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == ADR_GLB) begin
      reg_rdata[GLB_EN_BIT]                 = glb_en;
      reg_rdata[GLB_RST_BIT]                = rst_all_q;
      reg_rdata[GLB_FRZ_BIT]                = freeze_all;
      reg_rdata[GLB_CSEL_LSB +: CSEL_W]     = core_sel;
    end else if (int'(reg_addr) == ADR_SUM) begin
      reg_rdata[NUM_CTR-1:0] = ovf_summary;
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (int'(reg_addr) == ADR_CFG_BASE + i) begin
        reg_rdata[CFG_EN_BIT]             = en_q[i];
        reg_rdata[CFG_IRQ_BIT]            = irqen_q[i];
        reg_rdata[CFG_SEL_LSB +: SEL_W]   = sel_q[i];
      end
      if (int'(reg_addr) == ADR_VAL_BASE + i) begin
        reg_rdata[CTR_W-1:0] = cnt_q[i];
      end
    end
  end

endmodule

// File: rtl/pmu_ctr_chk.sv
module pmu_ctr_chk #(
  parameter int NUM_CTR  = 4,
  parameter int CTR_W    = 48,
  parameter int NUM_CORE = 4,
  parameter int CSEL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CTR*CTR_W-1:0] ctr_val,
  input logic [NUM_CTR-1:0]       ovf_summary,
  input logic [NUM_CORE-1:0]      irq,
  input logic                     ovf_hit,
  input logic                     glb_en,
  input logic                     freeze_all,
  input logic                     rst_all_q,
  input logic [CSEL_W-1:0]        core_sel,
  input logic                     glb_wr,
  input logic                     sum_wr,
  input logic [NUM_CTR-1:0]       val_wr
);

  // R9: at most one core interrupted
  a_r9_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R9: a pulse only follows an enabled wrap
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(ovf_hit));

  // R9: an enabled wrap with an in-range core reaches that core
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && (int'(core_sel) < NUM_CORE)) |=> $onehot(irq));

  // R8: freeze clears the master enable
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && freeze_all) |=> !glb_en);

  // R2: nothing moves while the master enable is off
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !(|val_wr) && !rst_all_q) |=> $stable(ctr_val));

  // R4: reset-all clears the counters and self-clears
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_all_q && !(|val_wr)) |=> (ctr_val == '0));
  a_r4_selfclr: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_all_q && !glb_wr) |=> !rst_all_q);

  // R6: summary bits are sticky outside a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!sum_wr && !rst_all_q) |=> ((ovf_summary & $past(ovf_summary)) == $past(ovf_summary)));

endmodule

bind pmu_ctr_top pmu_ctr_chk #(
  .NUM_CTR  (NUM_CTR),
  .CTR_W    (CTR_W),
  .NUM_CORE (NUM_CORE),
  .CSEL_W   (CSEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctr_val     (ctr_val),
  .ovf_summary (ovf_summary),
  .irq         (irq),
  .ovf_hit     (ovf_hit),
  .glb_en      (glb_en),
  .freeze_all  (freeze_all),
  .rst_all_q   (rst_all_q),
  .core_sel    (core_sel),
  .glb_wr      (glb_wr),
  .sum_wr      (sum_wr),
  .val_wr      (val_wr)
);

// File: tb/pmu_ctr_top_tb.sv
module pmu_ctr_top_tb;

  localparam int NC = 4;
  localparam int CW = 48;
  localparam logic [63:0] MAXV = 64'h0000_FFFF_FFFF_FFFF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     evt_in = '0;
  logic           reg_wr = 1'b0;
  logic [5:0]     reg_addr = '0;
  logic [63:0]    reg_wdata = '0;
  logic [63:0]    reg_rdata;
  logic [NC*CW-1:0] ctr_val;
  logic [NC-1:0]  ovf_summary;
  logic [3:0]     irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pmu_ctr_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctr_val(ctr_val), .ovf_summary(ovf_summary), .irq(irq)
  );

  function automatic logic [63:0] cv(input int i);
    return {16'h0, ctr_val[i*CW +: CW]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] ev);
    evt_in = ev;
    @(posedge clk);
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    reg_addr = 6'(a);
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int t);
    return 8'((t * 73) + (t * t * 5) + 3);
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r;
    logic [63:0] hold [NC];
    int exp_c [NC];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < NC; i++) chk("R1 counter", cv(i), 0);
    chk("R1 summary", 64'(ovf_summary), 0);
    chk("R1 irq", 64'(irq), 0);
    rd('h00, r); chk("R1 control", r, 0);
    rd('h08, r); chk("R1 config", r, 0);

    // R2 hierarchical enable
    for (int i = 0; i < NC; i++) wr('h08 + i, 64'((i << 8) | 1));
    repeat (5) cyc(8'hFF);
    for (int i = 0; i < NC; i++) chk("R2 master off", cv(i), 0);
    wr('h00, 64'h1);
    repeat (3) cyc(8'hFF);
    for (int i = 0; i < NC; i++) chk("R2 both on", cv(i), 3);
    wr('h09, 64'(1 << 8));
    repeat (2) cyc(8'hFF);
    chk("R2 local on", cv(0), 5);
    chk("R2 local off", cv(1), 3);

    // R4 reset-all
    wr('h00, 64'h3);
    cyc(8'h00);
    for (int i = 0; i < NC; i++) chk("R4 cleared", cv(i), 0);
    rd('h00, r); chk("R4 self clear", r, 64'h1);

    // R3 select sweep, every code
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int i = 0; i < NC; i++) wr('h08 + i, 64'(((i + 4 * rnd) << 8) | 1));
      wr('h00, 64'h3);
      cyc(8'h00);
      for (int i = 0; i < NC; i++) exp_c[i] = 0;
      for (int t = 0; t < 40; t++) begin
        for (int i = 0; i < NC; i++) if (pat(t)[i + 4 * rnd]) exp_c[i]++;
        cyc(pat(t));
      end
      for (int i = 0; i < NC; i++) chk("R3 select count", cv(i), 64'(exp_c[i]));
    end

    // R5 R6 R9 enabled wrap, core 2, no freeze
    wr('h00, 64'h1 | (64'd2 << 4));
    wr('h10, MAXV - 2);
    wr('h08, 64'h3);
    cyc(8'h01); chk("R5 approach", cv(0), MAXV - 1);
    cyc(8'h01); chk("R5 all ones", cv(0), MAXV);
    chk("R9 no early irq", 64'(irq), 0);
    cyc(8'h01);
    chk("R5 wrap to zero", cv(0), 0);
    chk("R6 summary set", 64'(ovf_summary), 64'h1);
    chk("R9 irq core 2", 64'(irq), 64'h4);
    rd('h00, r); chk("R8 no freeze keeps enable", r[0], 1);
    cyc(8'h00); chk("R9 single pulse", 64'(irq), 0);
    cyc(8'h01); chk("R5 continues", cv(0), 1);
    repeat (3) cyc(8'h00);
    chk("R6 sticky", 64'(ovf_summary), 64'h1);
    wr('h01, 64'h2); chk("R7 other bit clear", 64'(ovf_summary), 64'h1);
    wr('h01, 64'h1); chk("R7 w1c", 64'(ovf_summary), 0);

    // R6 wrap without interrupt enable
    wr('h09, 64'((1 << 8) | 1));
    wr('h11, MAXV);
    cyc(8'h02);
    chk("R6 plain wrap value", cv(1), 0);
    chk("R6 no summary", 64'(ovf_summary), 0);
    chk("R6 no irq", 64'(irq), 0);

    // R9 out-of-range core select
    wr('h00, 64'h1 | (64'd5 << 4));
    wr('h10, MAXV);
    cyc(8'h01);
    chk("R9 out of range summary", 64'(ovf_summary), 64'h1);
    chk("R9 out of range no irq", 64'(irq), 0);
    wr('h01, 64'hF);

    // R8 freeze with irq to core 1
    wr('h00, 64'h1 | 64'h4 | (64'd1 << 4));
    wr('h0A, 64'((2 << 8) | 3));
    wr('h12, MAXV);
    cyc(8'h04);
    chk("R9 irq with freeze", 64'(irq), 64'h2);
    rd('h00, r); chk("R8 enable cleared", r[0], 0);
    chk("R6 freeze summary", 64'(ovf_summary), 64'h4);
    for (int i = 0; i < NC; i++) hold[i] = cv(i);
    repeat (3) cyc(8'hFF);
    for (int i = 0; i < NC; i++) chk("R8 frozen", cv(i), hold[i]);

    // R7 R9 same-edge: two wraps plus a summary clear
    wr('h01, 64'hF);
    wr('h00, 64'h1 | (64'd3 << 4));
    wr('h08, 64'h3);
    wr('h0B, 64'((3 << 8) | 3));
    wr('h10, MAXV);
    wr('h13, MAXV);
    evt_in = 8'h09; reg_wr = 1'b1; reg_addr = 6'h01; reg_wdata = 64'hF;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    chk("R7 set wins over clear", 64'(ovf_summary), 64'h9);
    chk("R9 joint wrap one pulse", 64'(irq), 64'h8);
    chk("R5 joint wrap ctr0", cv(0), 0);
    chk("R5 joint wrap ctr3", cv(3), 0);
    cyc(8'h00); chk("R9 joint pulse ends", 64'(irq), 0);

    // R10 value write wins over count
    evt_in = 8'h01; reg_wr = 1'b1; reg_addr = 6'h10; reg_wdata = 64'd100;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    chk("R10 write wins", cv(0), 100);
    cyc(8'h01); chk("R10 counts after load", cv(0), 101);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule